// File: doc/BRIEF.md
# Register-mapped half-duplex SPI master

This block is a serial-peripheral master that sits behind a simple synchronous register bus. Software programs two configuration registers, loads a transmit word, and then issues either a transmit-only or a receive-only shift command through a control register. Each command carries a word length of up to 32 bits. The block divides the functional clock down to the serial clock and shifts the word most-significant bit first. When the shift finishes it sets a sticky completion flag for that direction, and it can raise an interrupt.

The same control register also carries a separate kind of command that drives two chip-select lines. Those lines are asserted and released only by that command and are never changed by a shift. Received words are right-justified across two 16-bit read registers. Transmit words are taken left-justified from the upper transmit register, so short words need no repacking by software.

Top module: `spi_regmap_master`

## Requirements
- R1: After reset, chip selects are inactive (`spi_cs_n` = 2'b11), `spi_sclk` and `spi_mosi` are 0, every register reads 0x0000, and `spi_irq` is 1 (negative-level polarity is the reset choice).
- R2: The register index is `bus_addr[3:1]`: 0 CFG_A, 1 CFG_B, 2 CTRL, 3 STATUS, 4 TX_LO, 5 TX_HI, 6 RX_LO, 7 RX_HI. The CFG_A fields are bit 0 clock enable, bits 3:1 divisor, bit 4 transmit-done interrupt enable and bit 5 receive-done interrupt enable. The CFG_B fields are bit 0 sample on rising edge, bit 5 positive interrupt level and bit 10 pulse interrupt mode. CTRL reads back bits 10:2 as last written, and its bits 1:0 read 0. Unused bits read 0, and the TX registers read back as written.
- R3: The serial clock idles low. During a shift each bit is one `spi_sclk` period of 2^(div+1) functional clocks, low half first.
- R4: A transmit command (CTRL bit 1 = 1, bit 0 = 0, bit 10 = 0) sends N = CTRL[6:2]+1 bits of {TX_HI, TX_LO}, starting from bit 31. `spi_mosi` is 0 whenever no transmit is in progress.
- R5: A transmit command with N of 8 or less is widened to a 16-bit frame. The sixteen bits sent are TX_HI[15:0].
- R6: A receive command (CTRL bit 0 = 1, bit 1 = 0, bit 10 = 0) samples N bits of `spi_miso`, first bit most significant. With CFG_B bit 0 = 1 it samples on the rising edge of `spi_sclk`, and with bit 0 = 0 on the falling edge. The result is right-justified: RX_LO holds bits 15:0 and RX_HI holds bits 31:16. `spi_mosi` stays 0 during a receive.
- R7: STATUS bit 0 sets when a receive ends and bit 1 sets when a transmit ends. Both bits are sticky. Writing STATUS clears each bit written as 0 and leaves each bit written as 1 unchanged.
- R8: A shift command is ignored in three cases: while CFG_A bit 0 is 0, when both CTRL bits 1:0 are set, and while a shift is in progress.
- R9: A CTRL write with bit 10 = 1 is a chip-select command and starts no shift. Bits 8:7 select the lines it affects. Bit 0 = 0 asserts those lines and bit 0 = 1 releases them. 0x05FC therefore asserts both lines and 0x05FD releases both.
- R10: The interrupt source is (STATUS[0] & receive enable) | (STATUS[1] & transmit enable) in level mode. In pulse mode the source is a single-cycle pulse as a flag sets with its enable on. `spi_irq` carries the source when the level bit is 1 and its inverse when the level bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Write when 1 with bus_sel |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 2 | Active-low chip selects |
| spi_irq | output | 1 | Interrupt request |

## Verification
A wrong bit counter or divisor state shows at the ports within a single word. The pin shows one `spi_sclk` edge too many or too few, or a period other than 2^(div+1) clocks, and the completion flag appears early, late or never. A wrong shift register or sample-edge choice shows as a corrupted bit in the pin stream or in RX_LO/RX_HI as soon as that word completes. A stale flag or chip-select state is visible on the next STATUS read or `spi_cs_n` sample, and a wrong interrupt state shows on `spi_irq` in the cycle after the flag sets.

// File: rtl/spi_rm_pkg.sv
package spi_rm_pkg;
    localparam int DATA_W  = 16;
    localparam int FRAME_W = 32;
    localparam int LEN_W   = 6;
    localparam int DIV_W   = 3;

    typedef enum logic [2:0] {
        RA_CFGA = 3'd0, RA_CFGB = 3'd1, RA_CTRL = 3'd2, RA_STAT = 3'd3,
        RA_TXLO = 3'd4, RA_TXHI = 3'd5, RA_RXLO = 3'd6, RA_RXHI = 3'd7
    } reg_sel_e;

    // control register field positions (decoded by the engine handoff)
    localparam int C_RD    = 0;
    localparam int C_WR    = 1;
    localparam int C_CSM   = 7;
    localparam int C_CSCMD = 10;

    typedef struct packed {
        logic             clk_en;
        logic [DIV_W-1:0] div;
        logic             wr_ie;
        logic             rd_ie;
        logic             samp_rise;
        logic             irq_pos;
        logic             irq_edge;
    } cfg_t;
endpackage

// File: rtl/spi_rm_engine.sv
module spi_rm_engine
    import spi_rm_pkg::*;
#(
    parameter int FW = FRAME_W,
    parameter int LW = LEN_W,
    parameter int DW = DIV_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_en,
    input  logic [DW-1:0] div,
    input  logic          samp_rise,
    input  logic          start,
    input  logic          start_rd,
    input  logic [LW-1:0] start_len_m1,
    input  logic [FW-1:0] tx_word,
    input  logic          miso,
    output logic          sclk,
    output logic          mosi,
    output logic          busy,
    output logic          done_rd,
    output logic          done_wr,
    output logic [FW-1:0] rx_word
);
    localparam int CNT_W = (1 << DW) - 1;

    typedef struct packed {
        logic             busy;
        logic             rd;
        logic             ph;
        logic [CNT_W-1:0] div_cnt;
        logic [LW-1:0]    bit_cnt;
        logic [LW-1:0]    len_m1;
        logic [FW-1:0]    tx_sr;
        logic [FW-1:0]    rx_sr;
        logic [FW-1:0]    rx_out;
        logic             done_rd;
        logic             done_wr;
    } eng_t;

    eng_t             q, d;
    logic [CNT_W-1:0] half_lim;
    logic [FW-1:0]    rx_n;

    always_comb begin
        d         = q;
        d.done_rd = 1'b0;
        d.done_wr = 1'b0;
        half_lim  = CNT_W'((32'd1 << div) - 32'd1);
        rx_n      = samp_rise ? q.rx_sr : {q.rx_sr[FW-2:0], miso};
        if (!q.busy) begin
            if (start) begin
                d.busy    = 1'b1;
                d.rd      = start_rd;
                d.len_m1  = start_len_m1;
                d.bit_cnt = '0;
                d.div_cnt = '0;
                d.ph      = 1'b0;
                d.tx_sr   = start_rd ? '0 : tx_word;
                d.rx_sr   = '0;
            end
        end else if (run_en) begin
            if (q.div_cnt != half_lim) begin
                d.div_cnt = q.div_cnt + 1'b1;
            end else begin
                d.div_cnt = '0;
                d.ph      = ~q.ph;
                if (!q.ph) begin
                    // rising edge of the serial clock
                    if (samp_rise) d.rx_sr = {q.rx_sr[FW-2:0], miso};
                end else begin
                    // falling edge: bit ends
                    d.rx_sr   = rx_n;
                    d.tx_sr   = q.tx_sr << 1;
                    d.bit_cnt = q.bit_cnt + 1'b1;
                    if (q.bit_cnt == q.len_m1) begin
                        d.busy = 1'b0;
                        if (q.rd) begin
                            d.rx_out  = rx_n;
                            d.done_rd = 1'b1;
                        end else begin
                            d.done_wr = 1'b1;
                        end
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sclk    = q.ph;
    assign mosi    = q.busy & ~q.rd & q.tx_sr[FW-1];
    assign busy    = q.busy;
    assign done_rd = q.done_rd;
    assign done_wr = q.done_wr;
    assign rx_word = q.rx_out;
endmodule

// File: rtl/spi_rm_regs.sv
module spi_rm_regs
    import spi_rm_pkg::*;
#(
    parameter int NUM_CS = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [3:0]         bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic               eng_busy,
    input  logic               done_rd,
    input  logic               done_wr,
    input  logic [FRAME_W-1:0] rx_word,
    output cfg_t               cfg,
    output logic               start,
    output logic               start_rd,
    output logic [LEN_W-1:0]   start_len_m1,
    output logic [FRAME_W-1:0] tx_word,
    output logic [1:0]         flags,
    output logic [NUM_CS-1:0]  cs_n,
    output logic               irq
);
    typedef struct packed {
        cfg_t              cfg;
        logic [8:0]        ctrl;
        logic [NUM_CS-1:0] cs_on;
        logic              st_rd;
        logic              st_wr;
        logic [DATA_W-1:0] tx_lo;
        logic [DATA_W-1:0] tx_hi;
        logic              irq_p;
    } regs_t;

    regs_t             q, d;
    reg_sel_e          sel;
    logic              wr_hit;
    logic [4:0]        wl;
    logic [NUM_CS-1:0] csm;
    logic              irq_src;
    logic              unused_addr_lsb;

    assign unused_addr_lsb = bus_addr[0];

    always_comb begin
        sel      = reg_sel_e'(bus_addr[3:1]);
        wr_hit   = bus_sel & bus_wr;
        wl       = bus_wdata[6:2];
        csm      = bus_wdata[C_CSM +: NUM_CS];
        start    = 1'b0;
        start_rd = bus_wdata[C_RD];
        // short transmit words go out as a 16-bit frame
        start_len_m1 = (bus_wdata[C_RD] || wl > 5'd7) ? {1'b0, wl} : LEN_W'(15);
        d        = q;
        d.irq_p  = (done_rd & q.cfg.rd_ie) | (done_wr & q.cfg.wr_ie);
        if (wr_hit) begin
            case (sel)
                RA_CFGA: begin
                    d.cfg.clk_en = bus_wdata[0];
                    d.cfg.div    = bus_wdata[3:1];
                    d.cfg.wr_ie  = bus_wdata[4];
                    d.cfg.rd_ie  = bus_wdata[5];
                end
                RA_CFGB: begin
                    d.cfg.samp_rise = bus_wdata[0];
                    d.cfg.irq_pos   = bus_wdata[5];
                    d.cfg.irq_edge  = bus_wdata[10];
                end
                RA_CTRL: begin
                    d.ctrl = bus_wdata[10:2];
                    if (bus_wdata[C_CSCMD]) begin
                        if (bus_wdata[C_RD]) d.cs_on = q.cs_on & ~csm;
                        else                 d.cs_on = q.cs_on | csm;
                    end else if ((bus_wdata[C_RD] ^ bus_wdata[C_WR]) &&
                                 q.cfg.clk_en && !eng_busy) begin
                        start = 1'b1;
                    end
                end
                RA_STAT: begin
                    d.st_rd = q.st_rd & bus_wdata[0];
                    d.st_wr = q.st_wr & bus_wdata[1];
                end
                RA_TXLO: d.tx_lo = bus_wdata;
                RA_TXHI: d.tx_hi = bus_wdata;
                default: ;
            endcase
        end
        if (done_rd) d.st_rd = 1'b1;
        if (done_wr) d.st_wr = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        case (sel)
            RA_CFGA: bus_rdata = {10'b0, q.cfg.rd_ie, q.cfg.wr_ie, q.cfg.div, q.cfg.clk_en};
            RA_CFGB: bus_rdata = {5'b0, q.cfg.irq_edge, 4'b0, q.cfg.irq_pos, 4'b0, q.cfg.samp_rise};
            RA_CTRL: bus_rdata = {5'b0, q.ctrl, 2'b0};
            RA_STAT: bus_rdata = {14'b0, q.st_wr, q.st_rd};
            RA_TXLO: bus_rdata = q.tx_lo;
            RA_TXHI: bus_rdata = q.tx_hi;
            RA_RXLO: bus_rdata = rx_word[15:0];
            default: bus_rdata = rx_word[31:16];
        endcase
        irq_src = q.cfg.irq_edge ? q.irq_p
                                 : ((q.st_rd & q.cfg.rd_ie) | (q.st_wr & q.cfg.wr_ie));
        irq     = q.cfg.irq_pos ? irq_src : ~irq_src;
    end

    assign cfg     = q.cfg;
    assign tx_word = {q.tx_hi, q.tx_lo};
    assign flags   = {q.st_wr, q.st_rd};
    assign cs_n    = ~q.cs_on;
endmodule

// File: rtl/spi_regmap_master.sv
module spi_regmap_master
    import spi_rm_pkg::*;
#(
    parameter int NUM_CS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [3:0]        bus_addr,
    input  logic [15:0]       bus_wdata,
    output logic [15:0]       bus_rdata,
    output logic              spi_sclk,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic [NUM_CS-1:0] spi_cs_n,
    output logic              spi_irq
);
    cfg_t               cfg;
    logic               start, start_rd;
    logic [LEN_W-1:0]   start_len_m1;
    logic [FRAME_W-1:0] tx_word, rx_word;
    logic               eng_busy, done_rd, done_wr;
    logic [1:0]         flags;

    spi_rm_regs #(.NUM_CS(NUM_CS)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_sel      (bus_sel),
        .bus_wr       (bus_wr),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .eng_busy     (eng_busy),
        .done_rd      (done_rd),
        .done_wr      (done_wr),
        .rx_word      (rx_word),
        .cfg          (cfg),
        .start        (start),
        .start_rd     (start_rd),
        .start_len_m1 (start_len_m1),
        .tx_word      (tx_word),
        .flags        (flags),
        .cs_n         (spi_cs_n),
        .irq          (spi_irq)
    );

    spi_rm_engine u_eng (
        .clk          (clk),
        .rst_n        (rst_n),
        .run_en       (cfg.clk_en),
        .div          (cfg.div),
        .samp_rise    (cfg.samp_rise),
        .start        (start),
        .start_rd     (start_rd),
        .start_len_m1 (start_len_m1),
        .tx_word      (tx_word),
        .miso         (spi_miso),
        .sclk         (spi_sclk),
        .mosi         (spi_mosi),
        .busy         (eng_busy),
        .done_rd      (done_rd),
        .done_wr      (done_wr),
        .rx_word      (rx_word)
    );
endmodule

// File: rtl/spi_rm_chk.sv
module spi_rm_chk #(
    parameter int NUM_CS = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [3:0]        bus_addr,
    input logic [15:0]       bus_wdata,
    input logic              spi_sclk,
    input logic              spi_mosi,
    input logic [NUM_CS-1:0] spi_cs_n,
    input logic              eng_busy,
    input logic              done_rd,
    input logic              done_wr,
    input logic [1:0]        flags,
    input logic              clk_en
);
    AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !eng_busy |-> !spi_sclk); // R3

    AST_MOSI_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !eng_busy |-> !spi_mosi); // R4

    AST_START_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eng_busy) |-> $past(clk_en)); // R8

    AST_DONE_ONE_DIRECTION: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done_rd, done_wr})); // R7

    AST_RD_FLAG_CLEARED_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flags[0]) |-> $past(bus_sel && bus_wr && bus_addr[3:1] == 3'd3)); // R7

    AST_WR_FLAG_CLEARED_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flags[1]) |-> $past(bus_sel && bus_wr && bus_addr[3:1] == 3'd3)); // R7

    AST_CS_ONLY_BY_COMMAND: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(spi_cs_n) |-> $past(bus_sel && bus_wr && bus_addr[3:1] == 3'd2 && bus_wdata[10])); // R9
endmodule

bind spi_regmap_master spi_rm_chk #(.NUM_CS(NUM_CS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .spi_sclk  (spi_sclk),
    .spi_mosi  (spi_mosi),
    .spi_cs_n  (spi_cs_n),
    .eng_busy  (eng_busy),
    .done_rd   (done_rd),
    .done_wr   (done_wr),
    .flags     (flags),
    .clk_en    (cfg.clk_en)
);

// File: tb/sim_spi_regmap_master.sv
`timescale 1ns/1ps
module sim_spi_regmap_master;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel = 1'b0, wr = 1'b0;
    logic [3:0]  addr = 4'd0;
    logic [15:0] wdata = 16'd0;
    logic [15:0] rdata;
    logic        sclk, mosi;
    logic        miso = 1'b0;
    logic [1:0]  cs_n;
    logic        irq;

    int n_chk = 0, n_fail = 0;
    int sclk_rises = 0, irq_hi = 0;
    logic irq_cnt_en = 1'b0;
    logic [15:0] ie_bits = 16'h0030;

    spi_regmap_master u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_wr(wr), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rdata), .spi_sclk(sclk), .spi_mosi(mosi),
        .spi_miso(miso), .spi_cs_n(cs_n), .spi_irq(irq)
    );

    always #10 clk = ~clk;
    always @(posedge sclk) sclk_rises++;
    always @(negedge clk) if (irq_cnt_en && irq === 1'b1) irq_hi++;

    function automatic logic [31:0] mask_hi(int n);
        return ~(32'hFFFF_FFFF >> n);
    endfunction
    function automatic logic [31:0] mask_lo(int n);
        return 32'hFFFF_FFFF >> (32 - n);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bwrite(logic [3:0] a, logic [15:0] v);
        @(negedge clk);
        sel = 1'b1; wr = 1'b1; addr = a; wdata = v;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0;
    endtask

    task automatic bread(logic [3:0] a, output logic [15:0] v);
        @(negedge clk);
        addr = a;
        #1 v = rdata;
    endtask

    task automatic wait_flag(int b, string req);
        logic [15:0] s;
        int i;
        s = '0; i = 0;
        while (!s[b] && i < 20000) begin
            bread(4'h6, s);
            i++;
        end
        if (!s[b]) check({req, " done flag"}, 32'(s[b]), 32'd1);
    endtask

    task automatic do_write(int dv, int len, logic [31:0] txw, string req);
        int eff;
        logic [31:0] got;
        realtime t0, t1;
        logic [15:0] s;
        eff = (len <= 8) ? 16 : len;
        got = '0; t0 = 0; t1 = 0;
        bwrite(4'h0, ie_bits | 16'h0001 | 16'(dv << 1));
        bwrite(4'h6, 16'h0000);
        bwrite(4'h8, txw[15:0]);
        bwrite(4'hA, txw[31:16]);
        fork
            begin
                for (int k = 0; k < eff; k++) begin
                    @(posedge sclk);
                    if (k == 0) t0 = $realtime;
                    if (k == 1) t1 = $realtime;
                    #1 got[31-k] = mosi;
                end
            end
            bwrite(4'h4, 16'(((len - 1) & 31) << 2) | 16'h0002);
        join
        wait_flag(1, req);
        check(req, got & mask_hi(eff), txw & mask_hi(eff));
        check("R3 sclk period", 32'(int'(t1 - t0)), 32'((2 << dv) * 20));
        bread(4'h6, s);
        check("R7 status after transmit", 32'(s), 32'h2);
    endtask

    task automatic do_read(int dv, bit rise, int len, logic [31:0] pat, string req);
        logic [15:0] lo, hi;
        int bad;
        bad = 0;
        bwrite(4'h2, rise ? 16'h0001 : 16'h0000);
        bwrite(4'h0, ie_bits | 16'h0001 | 16'(dv << 1));
        bwrite(4'h6, 16'h0000);
        fork
            begin
                miso = pat[len-1];
                for (int k = 0; k < len; k++) begin
                    @(negedge sclk);
                    if (mosi !== 1'b0) bad++;
                    #2;
                    if (k < len - 1) miso = pat[len-2-k];
                end
            end
            bwrite(4'h4, 16'(((len - 1) & 31) << 2) | 16'h0001);
        join
        wait_flag(0, req);
        bread(4'hC, lo);
        bread(4'hE, hi);
        check(req, {hi, lo}, pat & mask_lo(len));
        check("R6 mosi low during receive", 32'(bad), 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [15:0] v;
        int r0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 cs_n", 32'(cs_n), 32'h3);
        check("R1 sclk", 32'(sclk), 32'h0);
        check("R1 mosi", 32'(mosi), 32'h0);
        check("R1 irq", 32'(irq), 32'h1);
        rst_n = 1'b1;
        for (int a = 0; a < 8; a++) begin
            bread(4'(a * 2), v);
            check("R1 register reset value", 32'(v), 32'h0);
        end

        // R2 register map
        bwrite(4'h0, 16'hFFFF); bread(4'h0, v); check("R2 CFG_A", 32'(v), 32'h003F);
        bwrite(4'h2, 16'hFFFF); bread(4'h2, v); check("R2 CFG_B", 32'(v), 32'h0421);
        bwrite(4'h2, 16'h0000);
        r0 = sclk_rises;
        bwrite(4'h4, 16'h03FF); bread(4'h4, v); check("R2 CTRL", 32'(v), 32'h03FC);
        repeat (60) @(negedge clk);
        check("R8 both command bits ignored", 32'(sclk_rises - r0), 32'd0);
        bwrite(4'h8, 16'h1234); bread(4'h8, v); check("R2 TX_LO", 32'(v), 32'h1234);
        bwrite(4'hA, 16'hBEEF); bread(4'hA, v); check("R2 TX_HI", 32'(v), 32'hBEEF);

        // R4 / R5 transmit length sweep
        for (int len = 4; len <= 32; len++) begin
            logic [31:0] w;
            w = 32'hC3A5_5A3C ^ (32'(len) * 32'h9E37_79B9);
            do_write(0, len, w, (len <= 8) ? "R5 short transmit widened" : "R4 transmit bits");
        end
        for (int dv = 1; dv <= 3; dv++) begin
            do_write(dv, 20, 32'h8E1F_6B2D ^ 32'(dv), "R3 R4 transmit with divisor");
        end
        do_write(7, 4, 32'h5AC3_0000, "R3 R5 slowest divisor");

        // R6 receive sweep, both sample edges
        for (int rise = 0; rise < 2; rise++) begin
            for (int len = 4; len <= 32; len++) begin
                do_read(0, rise[0], len, 32'h6D2B_79F1 ^ (32'(len) * 32'h0101_0103), "R6 receive bits");
            end
        end
        do_read(2, 1'b1, 12, 32'h0000_0A5C, "R6 receive divided clock");

        // R7 sticky flags and selective clear
        do_write(0, 16, 32'hF00F_0000, "R4 transmit before flag test");
        bread(4'h6, v); check("R7 read flag held", 32'(v), 32'h2);
        bwrite(4'h6, 16'h0001); bread(4'h6, v); check("R7 write 1 keeps, 0 clears", 32'(v), 32'h0);

        // R8 ignored commands
        bwrite(4'h0, 16'h0030);
        r0 = sclk_rises;
        bwrite(4'h4, 16'h003E);
        repeat (100) @(negedge clk);
        check("R8 disabled clock ignores start", 32'(sclk_rises - r0), 32'd0);
        bread(4'h6, v); check("R8 no flag when disabled", 32'(v), 32'h0);
        bwrite(4'h0, 16'h0035);
        r0 = sclk_rises;
        bwrite(4'h4, 16'h003E);
        bwrite(4'h4, 16'h001D);
        wait_flag(1, "R8 busy");
        repeat (300) @(negedge clk);
        check("R8 start while busy ignored edges", 32'(sclk_rises - r0), 32'd16);
        bread(4'h6, v); check("R8 start while busy ignored flag", 32'(v), 32'h2);

        // R9 chip selects
        r0 = sclk_rises;
        bwrite(4'h4, 16'h05FC); @(negedge clk); check("R9 assert both", 32'(cs_n), 32'h0);
        do_write(0, 16, 32'h1234_0000, "R4 transmit with selects held");
        check("R9 shift leaves selects", 32'(cs_n), 32'h0);
        r0 = sclk_rises;
        bwrite(4'h4, 16'h05FD); @(negedge clk); check("R9 release both", 32'(cs_n), 32'h3);
        repeat (40) @(negedge clk);
        check("R9 select command starts no shift", 32'(sclk_rises - r0), 32'd0);
        bwrite(4'h4, 16'h0480); @(negedge clk); check("R9 assert line0", 32'(cs_n), 32'h2);
        bwrite(4'h4, 16'h0501); @(negedge clk); check("R9 release line1 only", 32'(cs_n), 32'h2);
        bwrite(4'h4, 16'h0481); @(negedge clk); check("R9 release line0", 32'(cs_n), 32'h3);

        // R10 interrupt
        bwrite(4'h2, 16'h0000);
        do_write(0, 16, 32'hAAAA_0000, "R10 transmit");
        check("R10 negative level active", 32'(irq), 32'h0);
        bwrite(4'h6, 16'h0000); @(negedge clk);
        check("R10 negative level idle", 32'(irq), 32'h1);
        bwrite(4'h2, 16'h0020);
        check("R10 positive level idle", 32'(irq), 32'h0);
        do_write(0, 16, 32'h5555_0000, "R10 transmit");
        check("R10 positive level active", 32'(irq), 32'h1);
        bwrite(4'h2, 16'h0420); bwrite(4'h6, 16'h0000);
        irq_hi = 0; irq_cnt_en = 1'b1;
        do_write(0, 12, 32'h3C3C_0000, "R10 transmit");
        repeat (20) @(negedge clk);
        irq_cnt_en = 1'b0;
        check("R10 pulse mode one cycle", 32'(irq_hi), 32'd1);
        check("R10 pulse mode low after", 32'(irq), 32'h0);
        ie_bits = 16'h0020;
        bwrite(4'h2, 16'h0020); bwrite(4'h6, 16'h0000);
        do_write(0, 16, 32'h0F0F_0000, "R10 transmit");
        check("R10 disabled enable keeps irq quiet", 32'(irq), 32'h0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule